// File: doc/BRIEF.md
# Double-Buffered Clocked Serial Transmitter

This block sends bytes over a two-wire clocked serial link: it produces the shift clock itself and drives a data line next to it. Each frame carries 8 data bits, least significant bit first, with one bit for each shift-clock period. A CPU-side write strobe hands a byte to the block. A mode input selects how that byte is used. In single-buffered operation each write starts one frame directly. In double-buffered operation a holding register sits in front of the shift register and reloads it automatically.

Completion is reported through a one-cycle interrupt pulse, a buffer-empty flag and a running flag. In double-buffered mode the interrupt marks each copy from the holding register into the shift register. When a frame ends and nothing is waiting, the clock simply stops and no interrupt is raised. The mode input and the divider input may only change while the block is not running.

Top module: `sio_dbuf_tx`

## Requirements
- R1: After a synchronous active-high reset, and whenever no frame is running, the clock output and the data output are both 1, the running flag is 0, the empty flag is 1 and the interrupt is 0.
- R2: A frame shifts out 8 bits, bit 0 first. Each bit is placed on the data line at a falling clock edge, and the data line stays constant while the clock is high during a frame.
- R3: Each clock half period lasts H system cycles, where H is the divider input, or 2 if the divider input is below 2. A full bit period lasts 2·H cycles.
- R4: In single-buffered mode (mode input 0), a write while idle starts a frame in the next cycle. The running flag stays high for exactly 16·H cycles, and one interrupt pulse appears in the cycle after the last bit period ends.
- R5: In single-buffered mode, a write while a frame is running is ignored: no extra frame is sent and no extra interrupt is raised. The empty flag stays 1.
- R6: In double-buffered mode (mode input 1), a write while idle loads the shift register directly. The interrupt pulses in the next cycle and the empty flag stays 1.
- R7: In double-buffered mode, a write while a frame is running stores the byte as pending and clears the empty flag. A further write before the reload replaces the pending byte.
- R8: In double-buffered mode, when a frame ends with a byte pending, the next frame starts with no idle cycle. The empty flag returns to 1 and one interrupt pulse is raised.
- R9: In double-buffered mode, when a frame ends with nothing pending, the clock stops high, the running flag falls and no interrupt is raised.
- R10: In double-buffered mode, a write in the same cycle as a frame's last bit period ending is treated as pending. It is sent next, in preference to any older pending byte.
- R11: The interrupt is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbl_en | input | 1 | 1 selects double-buffered mode |
| div_half | input | DIVW | Requested half period of the shift clock, in system cycles |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | NB | Byte to send |
| sclk_o | output | 1 | Generated shift clock, idles high |
| sdat_o | output | 1 | Serial data, idles high |
| irq_o | output | 1 | One-cycle transmit interrupt |
| empty_o | output | 1 | Holding buffer empty |
| busy_o | output | 1 | Frame in progress |

## Verification
The critical collision is a CPU write that lands in the same cycle as the last bit period of the current frame ending, either with the holding register empty or with an older byte already pending. The bench counts negative edges from the first write and places the second write so that its strobe is sampled at exactly the frame-ending edge. It then judges the result from the port side alone. The received byte stream must show the written byte sent next, the running flag must stay high for exactly two frame lengths with no gap, and exactly two interrupt pulses must be counted.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  localparam int FRAME_BITS = 8;
  localparam int MIN_HALF   = 2;

  // Effective half period: requests below the minimum are clamped up.
  function automatic int unsigned eff_half(input int unsigned req);
    return (req < MIN_HALF) ? MIN_HALF : req;
  endfunction
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen
  import sio_tx_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            stop,
  input  logic [DIVW-1:0] div_half,
  output logic            sclk,
  output logic            bit_end
);
  logic [DIVW-1:0] half_q;
  logic [DIVW-1:0] cnt;
  logic            run;
  logic            half_done;

  assign half_done = (cnt == half_q - DIVW'(1));
  // end of the high phase of a bit period
  assign bit_end   = run & sclk & half_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      sclk   <= 1'b1;
      cnt    <= '0;
      half_q <= DIVW'(MIN_HALF);
    end else if (start) begin
      run    <= 1'b1;
      sclk   <= 1'b0;
      cnt    <= '0;
      half_q <= DIVW'(eff_half(32'(div_half)));
    end else if (stop) begin
      run  <= 1'b0;
      sclk <= 1'b1;
      cnt  <= '0;
    end else if (run) begin
      if (half_done) begin
        cnt  <= '0;
        sclk <= ~sclk;
      end else begin
        cnt <= cnt + DIVW'(1);
      end
    end
  end

  // R3: a rising clock edge follows at least two low cycles
  a_r3_min_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> ($past(sclk, 1) == 1'b0 && $past(sclk, 2) == 1'b0));

  // R1: the clock is held high whenever the generator is stopped
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> sclk);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NB-1:0] ld_data,
  input  logic          adv,
  output logic          sdat,
  output logic          last
);
  localparam int CW = $clog2(NB);

  logic [NB-1:0] sh;
  logic [CW-1:0] idx;
  logic          act;

  assign sdat = sh[0];
  assign last = act && (idx == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '1;
      idx <= '0;
      act <= 1'b0;
    end else if (load) begin
      sh  <= ld_data;
      idx <= '0;
      act <= 1'b1;
    end else if (adv) begin
      if (last) begin
        sh  <= '1;
        idx <= '0;
        act <= 1'b0;
      end else begin
        sh  <= {1'b1, sh[NB-1:1]};
        idx <= idx + 1'b1;
      end
    end
  end

  // R2: bit periods only advance while a frame is loaded
  a_r2_adv_active: assert property (@(posedge clk) disable iff (rst)
    adv |-> act);
endmodule

// File: rtl/sio_holdbuf.sv
module sio_holdbuf #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          consume,
  input  logic [NB-1:0] wr_data,
  output logic [NB-1:0] hold,
  output logic          valid,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= '0;
      valid <= 1'b0;
      empty <= 1'b1;
    end else if (consume) begin
      valid <= 1'b0;
      empty <= 1'b1;
    end else if (capture) begin
      hold  <= wr_data;
      valid <= 1'b1;
      empty <= 1'b0;
    end
  end

  // R7: a stored byte clears the empty flag
  a_r7_capture_clears: assert property (@(posedge clk) disable iff (rst)
    (capture && !consume) |=> (!empty && valid && hold == $past(wr_data)));
endmodule

// File: rtl/sio_dbuf_tx.sv
module sio_dbuf_tx
  import sio_tx_pkg::*;
#(
  parameter int DIVW = 8,
  parameter int NB   = FRAME_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dbl_en,
  input  logic [DIVW-1:0] div_half,
  input  logic            wr_en,
  input  logic [NB-1:0]   wr_data,
  output logic            sclk_o,
  output logic            sdat_o,
  output logic            irq_o,
  output logic            empty_o,
  output logic            busy_o
);
  // named internal events
  logic          bit_end;
  logic          last_bit;
  logic          frame_end;
  logic          pend;
  logic          load;
  logic          stop;
  logic          capture;
  logic          consume;
  logic [NB-1:0] hold;
  logic          hold_valid;
  logic [NB-1:0] ld_data;
  logic          busy_q;
  logic          irq_q;

  assign frame_end = bit_end & last_bit;
  assign pend      = hold_valid | wr_en;
  assign load      = dbl_en ? ((wr_en & ~busy_q) | (frame_end & pend))
                            : (wr_en & ~busy_q);
  assign stop      = frame_end & ~load;
  assign capture   = dbl_en & wr_en & busy_q & ~frame_end;
  assign consume   = dbl_en & load;
  assign ld_data   = wr_en ? wr_data : hold;

  sio_clkgen #(.DIVW(DIVW)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .start   (load),
    .stop    (stop),
    .div_half(div_half),
    .sclk    (sclk_o),
    .bit_end (bit_end)
  );

  sio_shifter #(.NB(NB)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .ld_data(ld_data),
    .adv    (bit_end),
    .sdat   (sdat_o),
    .last   (last_bit)
  );

  sio_holdbuf #(.NB(NB)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .capture(capture),
    .consume(consume),
    .wr_data(wr_data),
    .hold   (hold),
    .valid  (hold_valid),
    .empty  (empty_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (load)      busy_q <= 1'b1;
      else if (stop) busy_q <= 1'b0;
      irq_q <= dbl_en ? load : frame_end;
    end
  end

  assign busy_o = busy_q;
  assign irq_o  = irq_q;

  // R11: interrupt is a single-cycle pulse
  a_r11_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R2: data held while the clock is high inside a frame
  a_r2_data_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_o && sclk_o && $past(sclk_o)) |-> $stable(sdat_o));

  // R9: frame end with nothing pending stops silently
  a_r9_silent_stop: assert property (@(posedge clk) disable iff (rst)
    (dbl_en && frame_end && !hold_valid && !wr_en) |=> (!busy_o && !irq_o && sclk_o));

  // R8 / R10: reload starts the next frame at once with an interrupt
  a_r8_reload_gapless: assert property (@(posedge clk) disable iff (rst)
    (dbl_en && frame_end && pend) |=> (busy_o && !sclk_o && irq_o && empty_o));

  // R4: single-buffered frame end drops running and interrupts
  a_r4_single_end: assert property (@(posedge clk) disable iff (rst)
    (!dbl_en && frame_end) |=> (!busy_o && irq_o));

  // R5: the empty flag never falls in single-buffered mode
  a_r5_single_empty: assert property (@(posedge clk) disable iff (rst)
    (!dbl_en && empty_o) |=> empty_o);
endmodule

// File: tb/test_sio_dbuf_tx.sv
module test_sio_dbuf_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbl_en = 1'b0;
  logic [7:0] div_half = 8'd2;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sclk_o, sdat_o, irq_o, empty_o, busy_o;

  always #5 clk = ~clk;

  sio_dbuf_tx #(.DIVW(8), .NB(8)) i_sio_dbuf_tx (
    .clk(clk), .rst(rst), .dbl_en(dbl_en), .div_half(div_half),
    .wr_en(wr_en), .wr_data(wr_data), .sclk_o(sclk_o), .sdat_o(sdat_o),
    .irq_o(irq_o), .empty_o(empty_o), .busy_o(busy_o)
  );

  int errs = 0;
  int checks = 0;
  int h_exp = 2;
  int irq_cnt = 0;
  int busy_cyc = 0;
  int cyc = 0;
  int last_rise = -1;
  int nb = 0;
  logic [7:0] sr = 8'h00;
  logic [7:0] rx_q[$];
  logic prev_sclk = 1'b1, prev_sdat = 1'b1, prev_irq = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  // port-side monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (busy_o) busy_cyc++;
      if (irq_o) begin
        irq_cnt++;
        chk(!prev_irq, "R11 irq width", 2, 1);
      end
      if (busy_o && prev_sclk && sclk_o)
        chk(sdat_o == prev_sdat, "R2 data stable while high", sdat_o, prev_sdat);
      if (!prev_sclk && sclk_o) begin
        sr = {sdat_o, sr[7:1]};
        nb++;
        if (last_rise >= 0)
          chk(cyc - last_rise == 2 * h_exp, "R3 bit period", cyc - last_rise, 2 * h_exp);
        last_rise = cyc;
        if (nb == 8) begin
          rx_q.push_back(sr);
          nb = 0;
        end
      end
      if (!busy_o) last_rise = -1;
    end
    prev_sclk = sclk_o;
    prev_sdat = sdat_o;
    prev_irq  = irq_o;
  end

  task automatic clr();
    rx_q.delete();
    irq_cnt = 0;
    busy_cyc = 0;
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] pat[4];
    pat[0] = 8'hA5; pat[1] = 8'h01; pat[2] = 8'h80; pat[3] = 8'h3C;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b1, "R1 sclk reset", sclk_o, 1);
    chk(sdat_o == 1'b1, "R1 sdat reset", sdat_o, 1);
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(empty_o == 1'b1, "R1 empty reset", empty_o, 1);
    chk(irq_o == 1'b0, "R1 irq reset", irq_o, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R4 / R3 / R2: single mode over divider values and patterns
    for (int d = 0; d < 6; d++) begin
      if (d == 4) continue;
      div_half = 8'(d);
      h_exp = half_of(d);
      for (int p = 0; p < 4; p++) begin
        #1 clr();
        do_write(pat[p]);
        wait_idle();
        chk(rx_q.size() == 1, "R4 one frame", rx_q.size(), 1);
        if (rx_q.size() == 1)
          chk(rx_q[0] == pat[p], "R2 byte lsb first", rx_q[0], pat[p]);
        chk(busy_cyc == 16 * h_exp, "R4 R3 running length", busy_cyc, 16 * h_exp);
        chk(irq_cnt == 1, "R4 one irq", irq_cnt, 1);
        chk(empty_o == 1'b1, "R5 empty stays set", empty_o, 1);
        chk(sclk_o && sdat_o, "R1 idle lines", {sclk_o, sdat_o}, 3);
      end
    end

    // R2: exhaustive byte sweep
    div_half = 8'd2;
    h_exp = 2;
    for (int b = 0; b < 256; b++) begin
      #1 clr();
      do_write(8'(b));
      wait_idle();
      chk(rx_q.size() == 1 && rx_q[0] == 8'(b), "R2 sweep byte",
          (rx_q.size() == 1) ? int'(rx_q[0]) : -1, b);
    end

    // R5: write while running is ignored in single mode
    #1 clr();
    do_write(8'h5A);
    repeat (3) @(negedge clk);
    do_write(8'hC3);
    #1;
    chk(empty_o == 1'b1, "R5 empty after busy write", empty_o, 1);
    wait_idle();
    chk(rx_q.size() == 1, "R5 frames sent", rx_q.size(), 1);
    if (rx_q.size() > 0) chk(rx_q[0] == 8'h5A, "R5 first byte kept", rx_q[0], 8'h5A);
    chk(irq_cnt == 1, "R5 irq count", irq_cnt, 1);

    // R6 R7 R8 R9: double mode with overwrite and reload
    dbl_en = 1'b1;
    div_half = 8'd3;
    h_exp = 3;
    repeat (2) @(negedge clk);
    #1 clr();
    do_write(8'h96);
    chk(irq_o == 1'b1, "R6 irq after idle load", irq_o, 1);
    chk(empty_o == 1'b1, "R6 empty after idle load", empty_o, 1);
    repeat (4) @(negedge clk);
    do_write(8'h11);
    chk(empty_o == 1'b0, "R7 empty cleared", empty_o, 0);
    do_write(8'hE7);
    chk(empty_o == 1'b0, "R7 still pending", empty_o, 0);
    wait_idle();
    chk(rx_q.size() == 2, "R7 R8 frame count", rx_q.size(), 2);
    if (rx_q.size() == 2) begin
      chk(rx_q[0] == 8'h96, "R6 first byte", rx_q[0], 8'h96);
      chk(rx_q[1] == 8'hE7, "R7 overwritten byte sent", rx_q[1], 8'hE7);
    end
    chk(busy_cyc == 32 * h_exp, "R8 no gap", busy_cyc, 32 * h_exp);
    chk(irq_cnt == 2, "R8 R9 irq count", irq_cnt, 2);
    chk(empty_o == 1'b1, "R8 empty set", empty_o, 1);
    chk(sclk_o == 1'b1, "R9 clock stopped high", sclk_o, 1);

    // R10: write lands on the frame-ending edge, nothing pending
    div_half = 8'd2;
    h_exp = 2;
    repeat (2) @(negedge clk);
    #1 clr();
    do_write(8'h3D);
    repeat (16 * 2 - 2) @(negedge clk);
    do_write(8'hB2);
    wait_idle();
    chk(rx_q.size() == 2, "R10 collision frames", rx_q.size(), 2);
    if (rx_q.size() == 2) chk(rx_q[1] == 8'hB2, "R10 collision byte", rx_q[1], 8'hB2);
    chk(busy_cyc == 64, "R10 no gap", busy_cyc, 64);
    chk(irq_cnt == 2, "R10 irq count", irq_cnt, 2);

    // R10: collision with an older pending byte
    repeat (2) @(negedge clk);
    #1 clr();
    do_write(8'h4E);
    repeat (3) @(negedge clk);
    do_write(8'h77);
    repeat (16 * 2 - 7) @(negedge clk);
    do_write(8'hC9);
    wait_idle();
    chk(rx_q.size() == 2, "R10 pending collision frames", rx_q.size(), 2);
    if (rx_q.size() == 2) chk(rx_q[1] == 8'hC9, "R10 newest wins", rx_q[1], 8'hC9);
    chk(busy_cyc == 64, "R10 pending no gap", busy_cyc, 64);
    chk(irq_cnt == 2, "R10 pending irq count", irq_cnt, 2);
    chk(empty_o == 1'b1, "R8 empty after collision", empty_o, 1);

    finish_run();
  end
endmodule